// File: doc/BRIEF.md
# Frame Base Address Register with Update Interrupt

This block sits in the register space of a display controller and owns the start address of the frame buffer that the fetch engine reads. Software may write a new start address at any moment. The write lands in a staging register and does not disturb the frame being scanned out. When the next frame-start strobe arrives, the staged address moves into the live register, and a status bit reports the move. Software uses that bit as its vertical-blank event. A move only happens if a new address was written since the previous move.

The block also holds a small interrupt controller. Bit 0 is the address-update source, and the remaining bits come from single-cycle event inputs. It has a raw status view, an enable mask, a masked view and a write-one-to-clear register. The interrupt output is high while any enabled source is pending. The register bus is a plain 32-bit port with a write strobe, a word offset and combinational read data.

Word offsets: 0 staged address (read/write), 1 live address (read only), 2 interrupt enable, 3 raw status (read only), 4 masked status (read only), 5 status clear (write only, reads 0). Offsets 6 and 7 are unused.

Top module: `fb_base_regs`

## Requirements
- R1: After reset every offset reads 0 and `irq` is low.
- R2: A write to offset 0 stores the data with bits 1:0 forced to 0, and offset 0 returns that value. Offset 1 keeps its value until a frame-start strobe moves it.
- R3: On a frame-start strobe with an address pending, offset 1 takes the staged value and raw status bit 0 is set. Both are visible the cycle after the strobe.
- R4: A frame-start strobe with nothing pending changes neither offset 1 nor raw bit 0.
- R5: If an address write and a frame-start strobe share a cycle, the previously staged value goes live. The new value stays pending and goes live at the following strobe.
- R6: Offset 4 reads raw AND enable, and `irq` is high exactly when that value is nonzero.
- R7: Writing 0 to offset 2 keeps `irq` low whatever the raw status holds.
- R8: A write to offset 5 clears each raw bit whose data bit is 1 and leaves every other raw bit unchanged.
- R9: When a set event and a clear of the same raw bit fall in one cycle, the bit ends up set.
- R10: A one-cycle pulse on `ext_evt[i]` sets raw status bit i+1.
- R11: Offset 5 and the unused offsets read 0. Writes to offsets 1, 3, 4, 6 and 7 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | One-cycle strobe at the start of each frame |
| ext_evt | input | NUM_SRC-1 | One-cycle event pulses for interrupt sources 1 and up |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | High while any enabled status bit is set |

## Verification
All register state changes at the clock edge that samples a write, strobe or event. Read data and `irq` follow the register contents combinationally, so every result is due one cycle after its stimulus. The bench drives inputs on the falling edge and reads back just after the next falling edge. Each check therefore sees exactly one rising edge between stimulus and sample. The simultaneous cases (write with strobe, set with clear) are driven inside a single falling-edge window, so the result shows the priority rule rather than the order in which the inputs were applied.

// File: rtl/fb_regs_pkg.sv
// Package: shared widths and register word offsets for the frame base block.
// Assumes a word-addressed bus with at most eight registers.
package fb_regs_pkg;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_BASE   = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_ACTIVE = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_IEN    = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_RAW    = 3'd3;
    localparam logic [ADDR_W-1:0] OFS_MASK   = 3'd4;
    localparam logic [ADDR_W-1:0] OFS_CLR    = 3'd5;
endpackage

// File: rtl/fb_base_shadow.sv
// Module: staged/live frame base address pair.
// Holds the software-written address and moves it to the live register on a
// frame-start strobe when a write is pending. The two low bits are dropped
// because the address is word aligned. Assumes frame_start is one cycle wide.
module fb_base_shadow #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start,
    input  logic          wr_base,
    input  logic [AW-1:0] wdata,
    output logic [AW-1:0] shadow_q,
    output logic [AW-1:0] active_q,
    output logic          swap
);
    logic pending_q;

    // Transfer fires only on a strobe with a staged write outstanding.
    assign swap = frame_start & pending_q;

    // Capture the staged address; a new write keeps it pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q  <= '0;
            pending_q <= 1'b0;
        end else begin
            if (wr_base) begin
                shadow_q <= {wdata[AW-1:2], 2'b00};
            end
            if (wr_base) begin
                pending_q <= 1'b1;
            end else if (frame_start) begin
                pending_q <= 1'b0;
            end
        end
    end

    // Move the staged value to the live register at a frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= '0;
        end else if (swap) begin
            active_q <= shadow_q;
        end
    end

    assert_transfer_R3: assert property (@(posedge clk) disable iff (!rst_n)
        swap |=> (active_q == $past(shadow_q)));

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !swap |=> $stable(active_q));

    // R5: a write in the strobe cycle must remain pending afterwards.
    assert_pend_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_base && frame_start) |=> pending_q);
endmodule

// File: rtl/fb_irq_ctrl.sv
// Module: raw/enable/masked interrupt status for NUM_SRC sources.
// Raw bits are set by one-cycle pulses and cleared by write-one-to-clear.
// A set wins over a clear in the same cycle. irq is the OR of masked bits.
module fb_irq_ctrl #(
    parameter int NUM_SRC = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] set_vec,
    input  logic               wr_en,
    input  logic [NUM_SRC-1:0] en_wdata,
    input  logic               wr_clr,
    input  logic [NUM_SRC-1:0] clr_data,
    output logic [NUM_SRC-1:0] raw_q,
    output logic [NUM_SRC-1:0] en_q,
    output logic               irq
);
    // Enable mask register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (wr_en) begin
            en_q <= en_wdata;
        end
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        // One raw status flop per source, set having priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                raw_q[i] <= 1'b0;
            end else if (set_vec[i]) begin
                raw_q[i] <= 1'b1;
            end else if (wr_clr && clr_data[i]) begin
                raw_q[i] <= 1'b0;
            end
        end

        assert_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[i] |=> raw_q[i]);

        assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_clr && clr_data[i] && !set_vec[i]) |=> !raw_q[i]);
    end

    // Output is high while any enabled source is pending.
    assign irq = |(raw_q & en_q);
endmodule

// File: rtl/fb_base_regs.sv
// Module: top of the frame base register block.
// Decodes a plain 32-bit register bus, drives the address pair and the
// interrupt controller, and returns read data combinationally.
// Source 0 is the address-update event; sources 1.. come from ext_evt.
module fb_base_regs
    import fb_regs_pkg::*;
#(
    parameter int NUM_SRC = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_start,
    input  logic [NUM_SRC-2:0] ext_evt,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               irq
);
    logic [DATA_W-1:0]  shadow_q;
    logic [DATA_W-1:0]  active_q;
    logic               swap;
    logic [NUM_SRC-1:0] raw_q;
    logic [NUM_SRC-1:0] en_q;
    logic               wr_base;
    logic               wr_en;
    logic               wr_clr;

    // Write strobes for the writable offsets.
    assign wr_base = reg_wr && (reg_addr == OFS_BASE);
    assign wr_en   = reg_wr && (reg_addr == OFS_IEN);
    assign wr_clr  = reg_wr && (reg_addr == OFS_CLR);

    fb_base_shadow #(.AW(DATA_W)) u_shadow (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .wr_base     (wr_base),
        .wdata       (reg_wdata),
        .shadow_q    (shadow_q),
        .active_q    (active_q),
        .swap        (swap)
    );

    fb_irq_ctrl #(.NUM_SRC(NUM_SRC)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  ({ext_evt, swap}),
        .wr_en    (wr_en),
        .en_wdata (reg_wdata[NUM_SRC-1:0]),
        .wr_clr   (wr_clr),
        .clr_data (reg_wdata[NUM_SRC-1:0]),
        .raw_q    (raw_q),
        .en_q     (en_q),
        .irq      (irq)
    );

    // Read multiplexer; unused and write-only offsets return zero.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_BASE:   reg_rdata = shadow_q;
            OFS_ACTIVE: reg_rdata = active_q;
            OFS_IEN:    reg_rdata[NUM_SRC-1:0] = en_q;
            OFS_RAW:    reg_rdata[NUM_SRC-1:0] = raw_q;
            OFS_MASK:   reg_rdata[NUM_SRC-1:0] = raw_q & en_q;
            default:    reg_rdata = '0;
        endcase
    end

    assert_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == OFS_MASK) |-> (irq == (reg_rdata != '0)));

    assert_mask_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_wdata[NUM_SRC-1:0] == '0) |=> !irq);

    assert_evt_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ext_evt[0] |=> raw_q[1]);
endmodule

// File: tb/fb_base_regs_tb.sv
module fb_base_regs_tb;
    localparam int NS = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_start = 1'b0;
    logic [NS-2:0] ext_evt = '0;
    logic          reg_wr = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          irq;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    fb_base_regs #(.NUM_SRC(NS)) u_dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .ext_evt(ext_evt),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic frame();
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic pulse_ext(input logic [NS-2:0] v);
        @(negedge clk);
        ext_evt = v;
        @(negedge clk);
        ext_evt = '0;
    endtask

    initial begin
        while (cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            check("R1 reset read", d, 32'h0);
        end
        check("R1 irq low", {31'b0, irq}, 32'h0);

        // R2: staged write with alignment, live unchanged
        wr(3'd0, 32'h1234_5677);
        rd(3'd0, d); check("R2 staged aligned", d, 32'h1234_5674);
        rd(3'd1, d); check("R2 live unchanged", d, 32'h0);

        // R3: strobe moves address and sets raw bit 0
        frame();
        rd(3'd1, d); check("R3 live updated", d, 32'h1234_5674);
        rd(3'd3, d); check("R3 raw bit0", d, 32'h1);

        // R4: strobe with nothing pending
        wr(3'd5, 32'hF);
        frame();
        rd(3'd1, d); check("R4 live held", d, 32'h1234_5674);
        rd(3'd3, d); check("R4 raw clear", d, 32'h0);

        // R5: write coincides with strobe
        wr(3'd0, 32'h0000_0100);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h0000_0204; frame_start = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0; frame_start = 1'b0;
        rd(3'd1, d); check("R5 old value live", d, 32'h0000_0100);
        rd(3'd0, d); check("R5 new value staged", d, 32'h0000_0204);
        frame();
        rd(3'd1, d); check("R5 new value live next frame", d, 32'h0000_0204);

        // R11: read-only / unused offsets ignore writes, write-only reads zero
        wr(3'd2, 32'h0);
        wr(3'd1, 32'hFFFF_FFFF);
        wr(3'd3, 32'h0);
        wr(3'd4, 32'hFFFF_FFFF);
        wr(3'd6, 32'hFFFF_FFFF);
        wr(3'd7, 32'hFFFF_FFFF);
        rd(3'd1, d); check("R11 live not writable", d, 32'h0000_0204);
        rd(3'd3, d); check("R11 raw not writable", d, 32'h1);
        rd(3'd2, d); check("R11 enable untouched", d, 32'h0);
        rd(3'd0, d); check("R11 staged untouched", d, 32'h0000_0204);
        rd(3'd5, d); check("R11 clear reads zero", d, 32'h0);
        rd(3'd6, d); check("R11 unused reads zero", d, 32'h0);
        rd(3'd7, d); check("R11 unused reads zero", d, 32'h0);

        // R9: set and clear of the same bits in one cycle
        wr(3'd5, 32'hF);
        wr(3'd0, 32'h40);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'd5; reg_wdata = 32'hF;
        ext_evt = 3'b001; frame_start = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0; ext_evt = '0; frame_start = 1'b0;
        rd(3'd3, d); check("R9 set wins", d, 32'h3);

        // R6, R7, R10: sweep raw pattern x enable pattern
        for (int r = 0; r < 16; r++) begin
            for (int e = 0; e < 16; e++) begin
                logic [3:0] rv;
                logic [3:0] ev;
                rv = 4'(r);
                ev = 4'(e);
                wr(3'd5, 32'hF);
                wr(3'd2, {28'b0, ev});
                if (rv[3:1] != 3'b0) pulse_ext(rv[3:1]);
                if (rv[0]) begin
                    wr(3'd0, 32'h1000 + 32'(r));
                    frame();
                end
                rd(3'd3, d); check("R10 raw from events", d, {28'b0, rv});
                rd(3'd4, d); check("R6 masked", d, {28'b0, rv & ev});
                check("R6 irq", {31'b0, irq}, {31'b0, |(rv & ev)});
                if (ev == 4'b0) check("R7 disabled irq low", {31'b0, irq}, 32'h0);
            end
        end

        // R8: clear sweep from all-set
        for (int c = 0; c < 16; c++) begin
            logic [3:0] cv;
            cv = 4'(c);
            wr(3'd5, 32'hF);
            pulse_ext(3'b111);
            wr(3'd0, 32'h2000);
            frame();
            wr(3'd5, {28'b0, cv});
            rd(3'd3, d); check("R8 clear pattern", d, {28'b0, ~cv});
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule